// File: doc/BRIEF.md
# GPIO Group Ownership Write Arbiter

This block decides, for one 32-pin GPIO bank, which bus master is allowed to change each pin's configuration and output state. The bank is split into 8-pin groups. Every group carries a 2-bit owner code that names either the primary host, the LPC host or a coprocessor; the fourth code is illegal. The low bit of each group's code lives in one command-source register and the high bit in a second one, both at the byte-aligned position of the group.

When a master issues a write to one of the ownership-controlled registers (output value, direction, interrupt setup, reset tolerance), the arbiter returns a registered per-bit write mask. Only the bits of groups owned by that master are enabled, so the GPIO datapath keeps every other bit. Writes to ungated registers such as debounce setup are passed with a full mask. Both command-source registers may be written by any master and can always be read. A group holding the illegal code is locked against every master and the write is flagged.

Top module: `gpio_own_arbiter`

## Requirements
- R1: After synchronous reset both command-source read views are zero (every group owned by the primary host, code 0), `mask_vld` is 0, `wr_mask` is 0 and `err_reserved` is 0.
- R2: A request with target 0 loads bit 8k of `req_wdata` as the low code bit of group k, and target 1 loads bit 8k as the high code bit; all other bits of the data are ignored and read back as 0 on `src_rd0`/`src_rd1`.
- R3: A request with target 2 (ownership-gated register) produces, one clock later, `mask_vld`=1 and a `wr_mask` whose 8-bit group k is all ones exactly when group k's code equals `req_master` (0 primary host, 1 LPC host, 2 coprocessor) and all zeros otherwise.
- R4: A gated request from master id 3 yields an all-zero mask.
- R5: A group whose code is 3 gets a zero mask for every master, and a gated request made while any group holds code 3 sets `err_reserved` for that result cycle.
- R6: A gated request made while no group holds code 3 leaves `err_reserved` at 0.
- R7: A request with target 3 (ungated register) yields `mask_vld`=1, an all-ones mask and `err_reserved`=0 whatever the owner codes are.
- R8: Any master id may write either command-source register; such a write produces no mask (`mask_vld`=0, `wr_mask`=0).
- R9: Writing one command-source register leaves the other unchanged, so a group moving from code 0 to code 2 by writing the high register first passes only through code 2 and never through code 3.
- R10: In a cycle after no request, `mask_vld`, `wr_mask` and `err_reserved` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Write request present this cycle |
| req_master | input | 2 | Requesting master id: 0 primary host, 1 LPC host, 2 coprocessor, 3 none |
| req_target | input | 2 | 0 command-source low, 1 command-source high, 2 gated register, 3 ungated register |
| req_wdata | input | 32 | Write data (used for command-source writes) |
| src_rd0 | output | 32 | Read view of low owner-bit register |
| src_rd1 | output | 32 | Read view of high owner-bit register |
| mask_vld | output | 1 | Registered mask valid for the previous cycle's request |
| wr_mask | output | 32 | Registered per-bit write enable |
| err_reserved | output | 1 | Gated write met a group with the illegal code |

## Verification
The bench walks owner patterns that mix all four codes across the groups and asks each master for its mask, so a decoder that swapped the two code bits, put the group bit at the wrong position or compared against the wrong master id would enable the wrong bytes. It writes the high register before the low one and checks the intermediate ownership, catching a design that cleared the other register or reached code 3 on the way. It targets the illegal code, where a faulty design would still grant the coprocessor or the host, or would stay silent on the error flag. It also checks that command-source writes and ungated writes bypass the ownership mask.

// File: rtl/gpio_own_pkg.sv
package gpio_own_pkg;
  typedef enum logic [1:0] {
    OWN_HOST  = 2'd0,
    OWN_LPC   = 2'd1,
    OWN_COPRO = 2'd2,
    OWN_RSVD  = 2'd3
  } owner_e;

  typedef enum logic [1:0] {
    TGT_SRC_LO = 2'd0,
    TGT_SRC_HI = 2'd1,
    TGT_GATED  = 2'd2,
    TGT_FREE   = 2'd3
  } target_e;
endpackage

// File: rtl/gpio_own_srcreg.sv
module gpio_own_srcreg #(
  parameter int BANK_W  = 32,
  parameter int GROUP_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we_lo,
  input  logic              we_hi,
  input  logic [BANK_W-1:0] wdata,
  output logic [BANK_W-1:0] src_lo,
  output logic [BANK_W-1:0] src_hi
);
  localparam int NUM_GROUPS = BANK_W / GROUP_W;

  function automatic logic [BANK_W-1:0] sparse_mask();
    logic [BANK_W-1:0] m;
    m = '0;
    for (int g = 0; g < NUM_GROUPS; g++) m[g*GROUP_W] = 1'b1;
    return m;
  endfunction

  localparam logic [BANK_W-1:0] SPARSE = sparse_mask();

  always_ff @(posedge clk) begin
    if (rst) begin
      src_lo <= '0;
      src_hi <= '0;
    end else begin
      if (we_lo) src_lo <= wdata & SPARSE;
      if (we_hi) src_hi <= wdata & SPARSE;
    end
  end
endmodule

// File: rtl/gpio_own_maskgen.sv
module gpio_own_maskgen #(
  parameter int BANK_W  = 32,
  parameter int GROUP_W = 8,
  parameter int NUM_GROUPS = BANK_W / GROUP_W
) (
  input  logic [NUM_GROUPS-1:0] grp_lo,
  input  logic [NUM_GROUPS-1:0] grp_hi,
  input  logic [1:0]            master,
  output logic [BANK_W-1:0]     mask,
  output logic                  rsvd_any
);
  import gpio_own_pkg::*;

  logic [NUM_GROUPS-1:0] rsvd;

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    logic [1:0] code;
    logic       owned;
    assign code    = {grp_hi[g], grp_lo[g]};
    assign rsvd[g] = (code == OWN_RSVD);
    assign owned   = (code == master) && !rsvd[g];
    assign mask[g*GROUP_W +: GROUP_W] = {GROUP_W{owned}};
  end

  assign rsvd_any = |rsvd;
endmodule

// File: rtl/gpio_own_arbiter.sv
module gpio_own_arbiter #(
  parameter int BANK_W  = 32,
  parameter int GROUP_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [1:0]        req_master,
  input  logic [1:0]        req_target,
  input  logic [BANK_W-1:0] req_wdata,
  output logic [BANK_W-1:0] src_rd0,
  output logic [BANK_W-1:0] src_rd1,
  output logic              mask_vld,
  output logic [BANK_W-1:0] wr_mask,
  output logic              err_reserved
);
  import gpio_own_pkg::*;

  localparam int NUM_GROUPS = BANK_W / GROUP_W;

  logic [BANK_W-1:0]     src_lo, src_hi;
  logic [NUM_GROUPS-1:0] grp_lo, grp_hi;
  logic [BANK_W-1:0]     gated_mask;
  logic                  rsvd_any;
  logic                  we_lo, we_hi;

  assign we_lo = req_valid && (req_target == TGT_SRC_LO);
  assign we_hi = req_valid && (req_target == TGT_SRC_HI);

  gpio_own_srcreg #(.BANK_W(BANK_W), .GROUP_W(GROUP_W)) u_src (
    .clk    (clk),
    .rst    (rst),
    .we_lo  (we_lo),
    .we_hi  (we_hi),
    .wdata  (req_wdata),
    .src_lo (src_lo),
    .src_hi (src_hi)
  );

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_pick
    assign grp_lo[g] = src_lo[g*GROUP_W];
    assign grp_hi[g] = src_hi[g*GROUP_W];
  end

  gpio_own_maskgen #(.BANK_W(BANK_W), .GROUP_W(GROUP_W), .NUM_GROUPS(NUM_GROUPS)) u_mask (
    .grp_lo   (grp_lo),
    .grp_hi   (grp_hi),
    .master   (req_master),
    .mask     (gated_mask),
    .rsvd_any (rsvd_any)
  );

  assign src_rd0 = src_lo;
  assign src_rd1 = src_hi;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_vld     <= 1'b0;
      wr_mask      <= '0;
      err_reserved <= 1'b0;
    end else if (req_valid && req_target == TGT_GATED) begin
      mask_vld     <= 1'b1;
      wr_mask      <= gated_mask;
      err_reserved <= rsvd_any;
    end else if (req_valid && req_target == TGT_FREE) begin
      mask_vld     <= 1'b1;
      wr_mask      <= '1;
      err_reserved <= 1'b0;
    end else begin
      mask_vld     <= 1'b0;
      wr_mask      <= '0;
      err_reserved <= 1'b0;
    end
  end
endmodule

// File: rtl/gpio_own_arbiter_chk.sv
module gpio_own_arbiter_chk #(
  parameter int BANK_W  = 32,
  parameter int GROUP_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic [1:0]        req_master,
  input logic [1:0]        req_target,
  input logic [BANK_W-1:0] src_rd0,
  input logic [BANK_W-1:0] src_rd1,
  input logic              mask_vld,
  input logic [BANK_W-1:0] wr_mask,
  input logic              err_reserved
);
  logic [BANK_W-1:0] rsv_bits;
  logic [BANK_W-1:0] sparse;

  always_comb begin
    for (int i = 0; i < BANK_W; i++) begin
      rsv_bits[i] = src_rd0[(i / GROUP_W) * GROUP_W] & src_rd1[(i / GROUP_W) * GROUP_W];
      sparse[i]   = (i % GROUP_W) == 0;
    end
  end

  AST_SRC_SPARSE: assert property (@(posedge clk) disable iff (rst)
    ((src_rd0 & ~sparse) == '0) && ((src_rd1 & ~sparse) == '0));  // R2

  AST_RESERVED_BLOCKED: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_target == 2'd2) |=> ((wr_mask & $past(rsv_bits)) == '0));  // R5

  AST_RESERVED_FLAG: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_target == 2'd2 && (|rsv_bits)) |=> err_reserved);  // R5

  AST_NO_OWNER_MASTER: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_target == 2'd2 && req_master == 2'd3) |=> (wr_mask == '0));  // R4

  AST_UNGATED_FULL: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_target == 2'd3) |=> (mask_vld && wr_mask == '1 && !err_reserved));  // R7

  AST_SRC_WRITE_NO_MASK: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_target[1] == 1'b0) |=> (!mask_vld && wr_mask == '0));  // R8

  AST_SRC_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(req_valid && req_target == 2'd0) |=> $stable(src_rd0));  // R9

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (!mask_vld && wr_mask == '0 && !err_reserved));  // R10
endmodule

bind gpio_own_arbiter gpio_own_arbiter_chk #(.BANK_W(BANK_W), .GROUP_W(GROUP_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .req_valid    (req_valid),
  .req_master   (req_master),
  .req_target   (req_target),
  .src_rd0      (src_rd0),
  .src_rd1      (src_rd1),
  .mask_vld     (mask_vld),
  .wr_mask      (wr_mask),
  .err_reserved (err_reserved)
);

// File: tb/tb_gpio_own_arbiter.sv
`timescale 1ns/1ps
module tb_gpio_own_arbiter;
  localparam int BW = 32;

  logic          clk = 1'b0;
  logic          rst;
  logic          req_valid;
  logic [1:0]    req_master;
  logic [1:0]    req_target;
  logic [BW-1:0] req_wdata;
  logic [BW-1:0] src_rd0, src_rd1, wr_mask;
  logic          mask_vld, err_reserved;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  gpio_own_arbiter #(.BANK_W(BW), .GROUP_W(8)) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_master(req_master),
    .req_target(req_target), .req_wdata(req_wdata), .src_rd0(src_rd0),
    .src_rd1(src_rd1), .mask_vld(mask_vld), .wr_mask(wr_mask),
    .err_reserved(err_reserved)
  );

  // vector: lo groups[42:39], hi groups[38:35], master[34:33], mask[32:1], err[0]
  localparam int NV = 8;
  localparam logic [42:0] VEC [NV] = '{
    {4'b0000, 4'b0000, 2'd0, 32'hFFFF_FFFF, 1'b0},
    {4'b0000, 4'b0000, 2'd1, 32'h0000_0000, 1'b0},
    {4'b0101, 4'b0000, 2'd1, 32'h00FF_00FF, 1'b0},
    {4'b0000, 4'b1100, 2'd2, 32'hFFFF_0000, 1'b0},
    {4'b0011, 4'b0110, 2'd0, 32'hFF00_0000, 1'b1},
    {4'b0011, 4'b0110, 2'd2, 32'h00FF_0000, 1'b1},
    {4'b1111, 4'b1111, 2'd0, 32'h0000_0000, 1'b1},
    {4'b1000, 4'b0100, 2'd3, 32'h0000_0000, 1'b0}
  };

  function automatic logic [BW-1:0] spread(input logic [3:0] g);
    logic [BW-1:0] v;
    v = '0;
    for (int k = 0; k < 4; k++) v[8*k] = g[k];
    return v;
  endfunction

  task automatic check(input string req, input logic [BW-1:0] act, input logic [BW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive one request for one cycle; on return the registered result is visible
  task automatic issue(input logic [1:0] m, input logic [1:0] t, input logic [BW-1:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_master = m; req_target = t; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    #100000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; req_valid = 1'b0; req_master = '0; req_target = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 src_rd0", src_rd0, '0);
    check("R1 src_rd1", src_rd1, '0);
    check("R1 mask_vld/err", {31'd0, mask_vld | err_reserved}, '0);

    // table walk: R2 R3 R4 R5 R6 R9
    for (int i = 0; i < NV; i++) begin
      logic [3:0] lo, hi;
      lo = VEC[i][42:39]; hi = VEC[i][38:35];
      issue(2'd1, 2'd1, spread(hi) | 32'h7E7E_7E7E);   // high register first (R9)
      issue(2'd2, 2'd0, spread(lo) | 32'hFEFE_FEFE);
      check("R2 src_rd0 readback", src_rd0, spread(lo));
      check("R2 src_rd1 readback", src_rd1, spread(hi));
      issue(VEC[i][34:33], 2'd2, 32'h0);
      check("R3/R4/R5 wr_mask", wr_mask, VEC[i][32:1]);
      check("R3 mask_vld", {31'd0, mask_vld}, 32'd1);
      check("R5/R6 err_reserved", {31'd0, err_reserved}, {31'd0, VEC[i][0]});
    end

    // R7 ungated write with reserved groups present
    issue(2'd1, 2'd3, 32'h0);
    check("R7 ungated mask", wr_mask, '1);
    check("R7 ungated err", {31'd0, err_reserved}, '0);
    check("R7 ungated vld", {31'd0, mask_vld}, 32'd1);

    // R8 command-source writes from several masters produce no mask
    issue(2'd3, 2'd0, 32'h0);
    check("R8 lo write from master 3 no vld", {31'd0, mask_vld}, '0);
    check("R8 lo write from master 3 mask", wr_mask, '0);
    issue(2'd0, 2'd1, 32'h0);
    check("R8 hi write from host no vld", {31'd0, mask_vld}, '0);
    check("R8 registers cleared", src_rd0 | src_rd1, '0);

    // R9 ordered migration of group 1 from host to coprocessor
    issue(2'd0, 2'd1, 32'h0000_0100);
    check("R9 lo untouched", src_rd0, '0);
    issue(2'd2, 2'd2, 32'h0);
    check("R9 copro owns group 1", wr_mask, 32'h0000_FF00);
    check("R9 no reserved on the way", {31'd0, err_reserved}, '0);
    issue(2'd0, 2'd0, 32'h0000_0100);
    issue(2'd2, 2'd2, 32'h0);
    check("R5 group 1 code 3 blocks copro", wr_mask, 32'h0000_0000);
    check("R5 flag", {31'd0, err_reserved}, 32'd1);

    // R10 idle cycle
    @(negedge clk);
    check("R10 idle mask", wr_mask, '0);
    check("R10 idle vld/err", {31'd0, mask_vld | err_reserved}, '0);

    // R1 reset mid-run
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R1 reset clears src", src_rd0 | src_rd1, '0);
    issue(2'd0, 2'd2, 32'h0);
    check("R1 host owns all after reset", wr_mask, '1);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule